// File: doc/BRIEF.md
# Display Link Packet Header and Blanking Generator

This block turns a packet request into a byte stream for a display serial link. A request gives a 6-bit data type, a 2-bit virtual channel, a 16-bit data/word-count field, a pad byte and a short/long selector. When the start strobe is sampled, the block forms the 24-bit header, adds an 8-bit error-correction byte and sends the four header bytes. Sync events and other short packets end there.

For a long blanking packet the header is followed by the pad byte repeated word-count times. A 16-bit CRC over exactly those payload bytes is computed as they leave and sent at the end. The stream has a valid flag and a last flag. Lane distribution and the physical layer belong to the blocks downstream.

Top module: `dl_blank_gen`

## Requirements
- R1: Header bytes leave in this order: byte 0 = {channel[1:0], type[5:0]}, byte 1 = word count bits 7:0, byte 2 = word count bits 15:8, byte 3 = ECC. The 24 header bits h[23:0] are bytes 0..2 with byte 0 in the low bits.
- R2: ECC bit k is the XOR of h masked by: k0 0xF12CB7, k1 0xF2555B, k2 0x749A6D, k3 0xB8E38E, k4 0xDF03F0, k5 0xEFFC00. ECC bits 7:6 are zero.
- R3: A short packet (long_pkt=0) is exactly 4 bytes, and out_last marks byte 3.
- R4: A long packet is the header, then the pad byte word-count times, then the CRC low byte and the CRC high byte. That is word count + 6 bytes, and out_last marks the CRC high byte.
- R5: The CRC uses the reflected polynomial 0x8408 and is preset to 0xFFFF. Each byte is processed least-significant bit first, and no final inversion is applied.
- R6: A long packet with word count 0 is the 4 header bytes followed by 0xFF, 0xFF.
- R7: A start strobe while busy is high is ignored. Input changes after the accepted start do not alter the packet in flight, and no extra packet follows.
- R8: While rst is high and on the cycle after it, out_valid, out_last and busy are low.
- R9: Byte 0 is shown on the clock edge that samples start, and the rest follow on consecutive cycles. busy is high from that edge until the last byte is shown. While out_last is shown, busy is low and a new start is accepted, so packets can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| long_pkt | input | 1 | 1 = long blanking packet with payload and CRC |
| data_type | input | 6 | Packet data type |
| vchan | input | 2 | Virtual channel |
| word_cnt | input | 16 | Header data field, payload length for long packets |
| pad_byte | input | 8 | Byte repeated as payload |
| out_byte | output | 8 | Stream byte |
| out_valid | output | 1 | out_byte holds a packet byte |
| out_last | output | 1 | Final byte of the packet |
| busy | output | 1 | A packet is being sent |

## Verification
The checker watches the stream on every cycle. It checks that a packet never breaks its valid run before the last byte, that out_last comes only with a valid byte and at index 3 or later, that ECC bits 7:6 of every header are zero, that busy rises together with byte 0 and drops when the last byte is shown, and the state after reset. The actual header bits, ECC values, pad repetition count and CRC bytes can only be confirmed by the bench scenarios. These scenarios compare every byte against a model built from the masks and the polynomial, and cover the zero-length payload, an ignored second strobe with different fields, back-to-back packets and a reset in the middle of a packet.

// File: rtl/dl_pkt_pkg.sv
package dl_pkt_pkg;

  localparam int HDR_BITS = 24;
  localparam int ECC_BITS = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_CRC_LO,
    ST_CRC_HI
  } seq_state_t;

  // coverage mask of each parity bit over the 24 header bits
  function automatic logic [HDR_BITS-1:0] ecc_mask(input int k);
    case (k)
      0:       ecc_mask = 24'hF12CB7;
      1:       ecc_mask = 24'hF2555B;
      2:       ecc_mask = 24'h749A6D;
      3:       ecc_mask = 24'hB8E38E;
      4:       ecc_mask = 24'hDF03F0;
      default: ecc_mask = 24'hEFFC00;
    endcase
  endfunction

  // one byte through a reflected CRC, lsb first
  function automatic logic [15:0] crc_byte(input logic [15:0] crc_in,
                                           input logic [7:0]  din,
                                           input logic [15:0] poly);
    logic [15:0] c;
    c = crc_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ din[b]) c = (c >> 1) ^ poly;
      else               c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/dl_hdr_ecc.sv
module dl_hdr_ecc
  import dl_pkt_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr,
  output logic [7:0]          ecc
);

  genvar k;
  generate
    for (k = 0; k < ECC_BITS; k++) begin : g_par
      assign ecc[k] = ^(hdr & ecc_mask(k));
    end
  endgenerate

  assign ecc[7:ECC_BITS] = '0;

endmodule

// File: rtl/dl_crc16.sv
module dl_crc16
  import dl_pkt_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h8408,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || clear) crc <= INIT;
    else if (en)      crc <= crc_byte(crc, din, POLY);
  end

endmodule

// File: rtl/dl_blank_gen.sv
module dl_blank_gen
  import dl_pkt_pkg::*;
#(
  parameter int          WC_W     = 16,
  parameter int          DT_W     = 6,
  parameter int          VC_W     = 2,
  parameter logic [15:0] CRC_POLY = 16'h8408,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            long_pkt,
  input  logic [DT_W-1:0] data_type,
  input  logic [VC_W-1:0] vchan,
  input  logic [WC_W-1:0] word_cnt,
  input  logic [7:0]      pad_byte,
  output logic [7:0]      out_byte,
  output logic            out_valid,
  output logic            out_last,
  output logic            busy
);

  localparam int WORD_W = HDR_BITS + 8;

  seq_state_t         state;
  logic [WORD_W-1:0]  hdr_q;
  logic [HDR_BITS-1:0] hdr_bits;
  logic [7:0]         ecc;
  logic [WORD_W-1:0]  hdr_word;
  logic               long_q;
  logic [7:0]         pad_q;
  logic [WC_W-1:0]    rem_q;
  logic [1:0]         idx_q;
  logic [15:0]        crc;
  logic               accept;

  assign hdr_bits = {word_cnt, vchan, data_type};
  assign hdr_word = {ecc, hdr_bits};
  assign accept   = (state == ST_IDLE) && start;
  assign busy     = (state != ST_IDLE);

  dl_hdr_ecc u_ecc (
    .hdr (hdr_bits),
    .ecc (ecc)
  );

  dl_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .en    (state == ST_PAY),
    .din   (pad_q),
    .crc   (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hdr_q     <= '0;
      long_q    <= 1'b0;
      pad_q     <= '0;
      rem_q     <= '0;
      idx_q     <= '0;
      out_byte  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            hdr_q     <= hdr_word;
            long_q    <= long_pkt;
            pad_q     <= pad_byte;
            rem_q     <= word_cnt;
            out_byte  <= hdr_word[7:0];
            out_valid <= 1'b1;
            idx_q     <= 2'd1;
            state     <= ST_HDR;
          end
        end
        ST_HDR: begin
          out_byte  <= hdr_q[{idx_q, 3'b000} +: 8];
          out_valid <= 1'b1;
          idx_q     <= idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            if (!long_q) begin
              out_last <= 1'b1;
              state    <= ST_IDLE;
            end else if (rem_q == '0) begin
              state <= ST_CRC_LO;
            end else begin
              state <= ST_PAY;
            end
          end
        end
        ST_PAY: begin
          out_byte  <= pad_q;
          out_valid <= 1'b1;
          rem_q     <= rem_q - 1'b1;
          if (rem_q == {{(WC_W-1){1'b0}}, 1'b1}) state <= ST_CRC_LO;
        end
        ST_CRC_LO: begin
          out_byte  <= crc[7:0];
          out_valid <= 1'b1;
          state     <= ST_CRC_HI;
        end
        ST_CRC_HI: begin
          out_byte  <= crc[15:8];
          out_valid <= 1'b1;
          out_last  <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dl_blank_gen_chk.sv
module dl_blank_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [7:0] out_byte,
  input logic       out_valid,
  input logic       out_last,
  input logic       busy
);

  // index of the byte currently shown within its packet
  logic [17:0] pos;

  always_ff @(posedge clk) begin
    if (rst)            pos <= '0;
    else if (out_valid) pos <= out_last ? '0 : pos + 1'b1;
  end

  assert_ecc_top_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && pos == 18'd3) |-> (out_byte[7:6] == 2'b00));

  assert_short_len_R3: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (pos >= 18'd3));

  assert_last_valid_R4: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_last && !busy));

  assert_no_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (out_valid && pos == 18'd0 && $past(start)));

  assert_last_frees_R9: assert property (@(posedge clk) disable iff (rst)
    out_last |-> !busy);

endmodule

bind dl_blank_gen dl_blank_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .out_byte  (out_byte),
  .out_valid (out_valid),
  .out_last  (out_last),
  .busy      (busy)
);

// File: tb/dl_blank_gen_test.sv
module dl_blank_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        long_pkt = 1'b0;
  logic [5:0]  data_type = '0;
  logic [1:0]  vchan = '0;
  logic [15:0] word_cnt = '0;
  logic [7:0]  pad_byte = '0;
  logic [7:0]  out_byte;
  logic        out_valid, out_last, busy;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [7:0] exp_b [0:79];
  int         exp_n;

  // {long, type, channel, word count, pad}
  localparam logic [32:0] VEC [0:7] = '{
    {1'b0, 6'h21, 2'd0, 16'h1234, 8'h00},
    {1'b0, 6'h31, 2'd3, 16'hBEEF, 8'h00},
    {1'b0, 6'h01, 2'd1, 16'h0000, 8'h00},
    {1'b0, 6'h3F, 2'd2, 16'hFFFF, 8'h00},
    {1'b1, 6'h19, 2'd0, 16'd4,    8'h00},
    {1'b1, 6'h19, 2'd1, 16'd10,   8'hA5},
    {1'b1, 6'h19, 2'd2, 16'd1,    8'hFF},
    {1'b1, 6'h29, 2'd3, 16'd37,   8'h5A}
  };

  dl_blank_gen uut (
    .clk(clk), .rst(rst), .start(start), .long_pkt(long_pkt),
    .data_type(data_type), .vchan(vchan), .word_cnt(word_cnt),
    .pad_byte(pad_byte), .out_byte(out_byte), .out_valid(out_valid),
    .out_last(out_last), .busy(busy)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] model_ecc(input logic [23:0] h);
    logic [23:0] m [0:5];
    logic [7:0] e;
    m[0] = 24'hF12CB7; m[1] = 24'hF2555B; m[2] = 24'h749A6D;
    m[3] = 24'hB8E38E; m[4] = 24'hDF03F0; m[5] = 24'hEFFC00;
    e = 8'h00;
    for (int k = 0; k < 6; k++) e[k] = $countones(h & m[k]) % 2;
    return e;
  endfunction

  task automatic build_exp(input logic lng, input logic [5:0] dt,
                           input logic [1:0] vc, input logic [15:0] wc,
                           input logic [7:0] pd);
    logic [23:0] h;
    logic [15:0] c;
    h = {wc, vc, dt};
    exp_b[0] = h[7:0]; exp_b[1] = h[15:8]; exp_b[2] = h[23:16];
    exp_b[3] = model_ecc(h);
    exp_n = 4;
    if (lng) begin
      c = 16'hFFFF;
      for (int i = 0; i < int'(wc); i++) begin
        exp_b[exp_n] = pd;
        exp_n++;
        for (int b = 0; b < 8; b++)
          c = (c[0] != pd[b]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      end
      exp_b[exp_n] = c[7:0];  exp_b[exp_n+1] = c[15:8];
      exp_n += 2;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic kick(input logic lng, input logic [5:0] dt, input logic [1:0] vc,
                      input logic [15:0] wc, input logic [7:0] pd);
    long_pkt = lng; data_type = dt; vchan = vc; word_cnt = wc; pad_byte = pd;
    start = 1'b1;
  endtask

  // called at a negedge right after kick: steps through the stream
  // poke_at >= 0: drive a stray start with other fields at that byte
  // chain: hold the next request (nx) on the last byte
  task automatic expect_stream(input string req, input int poke_at, input bit chain,
                               input logic [32:0] nx);
    int bad_i, bad_a, bad_e;
    bad_i = -1; bad_a = 0; bad_e = 0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < exp_n; k++) begin
      if (bad_i < 0 && (!out_valid || out_byte != exp_b[k] ||
                        out_last != (k == exp_n - 1) || busy != (k != exp_n - 1))) begin
        bad_i = k; bad_a = {out_valid, out_last, busy, out_byte};
        bad_e = {1'b1, (k == exp_n - 1), (k != exp_n - 1), exp_b[k]};
      end
      start = 1'b0;
      if (k == poke_at) kick(~long_pkt, ~data_type, ~vchan, 16'd3, ~pad_byte);
      if (chain && k == exp_n - 1) kick(nx[32], nx[31:26], nx[25:24], nx[23:8], nx[7:0]);
      @(negedge clk);
    end
    check(bad_i < 0, req, $sformatf("stream byte %0d {valid,last,busy,byte}", bad_i),
          bad_a, bad_e);
    if (!chain) check(!out_valid && !busy, req, "idle after last byte",
                      {out_valid, busy}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; tests++;
        $display("FAIL watchdog expired: actual %0d expected < 100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    check(!out_valid && !out_last && !busy, "R8", "outputs in reset",
          {out_valid, out_last, busy}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !busy, "R8", "idle after reset", {out_valid, busy}, 0);

    // R1 R2 R3 R4 R5: table walk
    for (int v = 0; v < 8; v++) begin
      build_exp(VEC[v][32], VEC[v][31:26], VEC[v][25:24], VEC[v][23:8], VEC[v][7:0]);
      kick(VEC[v][32], VEC[v][31:26], VEC[v][25:24], VEC[v][23:8], VEC[v][7:0]);
      expect_stream(VEC[v][32] ? "R1/R2/R4/R5" : "R1/R2/R3", -1, 1'b0, '0);
      @(negedge clk);
    end

    // R6 zero-length payload
    build_exp(1'b1, 6'h19, 2'd1, 16'd0, 8'h77);
    check(exp_b[4] == 8'hFF && exp_b[5] == 8'hFF && exp_n == 6, "R6",
          "model empty crc", {exp_b[5], exp_b[4]}, 16'hFFFF);
    kick(1'b1, 6'h19, 2'd1, 16'd0, 8'h77);
    expect_stream("R6", -1, 1'b0, '0);

    // R7 stray start mid-packet ignored
    build_exp(1'b1, 6'h19, 2'd2, 16'd5, 8'h3C);
    kick(1'b1, 6'h19, 2'd2, 16'd5, 8'h3C);
    expect_stream("R7", 2, 1'b0, '0);
    build_exp(1'b0, 6'h11, 2'd0, 16'h00AB, 8'h00);
    kick(1'b0, 6'h11, 2'd0, 16'h00AB, 8'h00);
    expect_stream("R7", 1, 1'b0, '0);

    // R9 back to back: second request held on the last byte
    build_exp(1'b1, 6'h19, 2'd0, 16'd2, 8'h81);
    kick(1'b1, 6'h19, 2'd0, 16'd2, 8'h81);
    expect_stream("R9", -1, 1'b1, {1'b0, 6'h01, 2'd3, 16'h5A5A, 8'h00});
    build_exp(1'b0, 6'h01, 2'd3, 16'h5A5A, 8'h00);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < exp_n; k++) begin
        start = 1'b0;
        if (!out_valid || out_byte != exp_b[k] || out_last != (k == 3)) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R9", "back-to-back second packet mismatches", bad, 0);
    end

    // R8 reset in the middle of a long packet
    kick(1'b1, 6'h19, 2'd0, 16'd20, 8'h12);
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!out_valid && !out_last && !busy, "R8", "after mid-packet reset",
          {out_valid, out_last, busy}, 0);
    repeat (3) @(negedge clk);
    check(!out_valid && !busy, "R8", "stays idle after reset", {out_valid, busy}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule